// File: doc/BRIEF.md
# Dual-Channel DDR Sample Word Rebuilder

This block receives the double-data-rate output of a two-channel 14-bit analog-to-digital converter and turns it back into whole parallel samples. Each channel arrives on seven data lanes. Every lane carries two bits in each period of the converter's output clock. It carries an even-numbered bit while that clock is low and the next odd-numbered bit while it is high. One extra lane carries the out-of-range indication for both channels at once, with one channel's flag in each half of the period.

The block runs on a sampling clock at twice the output-clock rate. On every sampling edge it is told, through `phase_hi`, which half of the output clock is being sampled. Placing that edge in the middle of each half keeps it away from the lane transitions. A word opens with a low half. When the high half that follows has been sampled, the two halves are interleaved into one 14-bit word per channel. The shared flag is split into one flag per channel, and both samples are presented together with a one-cycle strobe. Electrical receivers, converter configuration and phase training are handled elsewhere.

Top module: `ddr_word_rebuild`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `out_valid`, both output words and both output flags to zero. It also forgets any low half already seen.
- R2: Lane k of a channel, sampled with `phase_hi` = 0, supplies bit 2k of that channel's output word.
- R3: Lane k of a channel, sampled with `phase_hi` = 1, supplies bit 2k+1 of that channel's output word.
- R4: A low-half edge directly followed by a high-half edge raises `out_valid` for exactly one cycle, right after the high-half edge. `out_valid` is low after every other edge.
- R5: A high-half edge that is not preceded by a low-half edge since reset or since the last word produces no word. The first word after reset therefore needs one full low half and then one full high half.
- R6: With `SWAP_OVF` = 0, the overflow lane sampled in the low half becomes `out_ovf_a` and the one sampled in the high half becomes `out_ovf_b`. With `SWAP_OVF` = 1 the two are exchanged. In both cases a 1 means out of range.
- R7: Between strobes, the output words and flags hold their last values whatever the lanes do.
- R8: Channels A and B are rebuilt independently from their own lanes in the same cycle and share one strobe.
- R9: When several low halves come in a row, the word uses the lane values of the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, twice the output-clock rate, edges mid-phase |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_hi | input | 1 | 1 when this edge samples the high half of the output clock |
| lane_a | input | 7 | Channel A DDR data lanes |
| lane_b | input | 7 | Channel B DDR data lanes |
| ovf_lane | input | 1 | Shared out-of-range lane |
| out_valid | output | 1 | One-cycle strobe for a new sample pair |
| out_word_a | output | 14 | Rebuilt channel A sample |
| out_word_b | output | 14 | Rebuilt channel B sample |
| out_ovf_a | output | 1 | Channel A out-of-range flag |
| out_ovf_b | output | 1 | Channel B out-of-range flag |

## Verification
On every cycle the assertions check the following: the strobe is a single-cycle pulse; it always follows a high half that was directly preceded by a low half; each output bit matches the lane value from the proper half two or one edges back; the flag split follows `SWAP_OVF`; and outputs stay unchanged between strobes. Only the bench's scenarios can show the sequence behaviour. These scenarios cover a lone high half after reset, repeated low halves where the last must win, and long idle stretches with changing lanes. A sweep over every 14-bit value on channel A, with B and both flags derived from it, shows that the bit ordering is correct in full.

// File: rtl/ddr_rx_pkg.sv
// Shared definitions for the DDR sample rebuilder.
// Assumes one sampling edge per output-clock half.
package ddr_rx_pkg;
    // Which half of the converter output clock an edge samples.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

    // Word-opening state of the phase tracker.
    typedef enum logic {
        WAIT_LOW  = 1'b0,
        HAVE_LOW  = 1'b1
    } track_e;
endpackage

// File: rtl/ddr_phase_tracker.sv
// Tracks output-clock halves. It flags edges where the low half must be
// captured, and it fires when a high half completes a word opened by a
// low half. Assumes phase_hi is valid on every edge.
module ddr_phase_tracker
    import ddr_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_hi,
    output logic cap_low,
    output logic fire
);
    track_e state_q;
    half_e  half_now;

    assign half_now = half_e'(phase_hi);
    assign cap_low  = (half_now == HALF_LOW);
    assign fire     = (half_now == HALF_HIGH) && (state_q == HAVE_LOW);

    // Open a word on a low half; any high half closes or discards it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WAIT_LOW;
        end else if (half_now == HALF_LOW) begin
            state_q <= HAVE_LOW;
        end else begin
            state_q <= WAIT_LOW;
        end
    end

    AST_FIRE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(rst_n)) |-> !$past(phase_hi)); // R5
endmodule

// File: rtl/ddr_lane_capture.sv
// Bank of per-lane registers that hold the value sampled in the low half.
// When several low halves come in a row, the last one overwrites the
// earlier values. Assumes cap_low is asserted only on low-half edges.
module ddr_lane_capture #(
    parameter int LANES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_low,
    input  logic [LANES-1:0] lanes_in,
    output logic [LANES-1:0] even_q
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Hold lane k's even-bit value until the next low half.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                even_q[k] <= 1'b0;
            end else if (cap_low) begin
                even_q[k] <= lanes_in[k];
            end
        end
    end

    AST_EVEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cap_low) && $past(rst_n)) |-> $stable(even_q)); // R7
endmodule

// File: rtl/ddr_word_assembler.sv
// Interleaves held even bits with the live odd bits into full words,
// splits the shared overflow lane into per-channel flags and registers
// everything under a one-cycle strobe. Assumes fire only on a closing
// high half.
module ddr_word_assembler #(
    parameter int LANES    = 7,
    parameter bit SWAP_OVF = 1'b0,
    localparam int WORD_W  = 2 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [LANES-1:0]  even_a,
    input  logic [LANES-1:0]  odd_a,
    input  logic [LANES-1:0]  even_b,
    input  logic [LANES-1:0]  odd_b,
    input  logic              ovf_even,
    input  logic              ovf_odd,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word_a,
    output logic [WORD_W-1:0] out_word_b,
    output logic              out_ovf_a,
    output logic              out_ovf_b
);
    logic [WORD_W-1:0] nxt_a;
    logic [WORD_W-1:0] nxt_b;
    logic              nxt_fa;
    logic              nxt_fb;

    for (genvar k = 0; k < LANES; k++) begin : g_mix
        assign nxt_a[2*k]     = even_a[k];
        assign nxt_a[2*k + 1] = odd_a[k];
        assign nxt_b[2*k]     = even_b[k];
        assign nxt_b[2*k + 1] = odd_b[k];
    end

    if (SWAP_OVF) begin : g_swap
        assign nxt_fa = ovf_odd;
        assign nxt_fb = ovf_even;
    end else begin : g_straight
        assign nxt_fa = ovf_even;
        assign nxt_fb = ovf_odd;
    end

    // Raise the strobe for one cycle per completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= fire;
        end
    end

    // Load the sample pair and flags when a word completes, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word_a <= '0;
            out_word_b <= '0;
            out_ovf_a  <= 1'b0;
            out_ovf_b  <= 1'b0;
        end else if (fire) begin
            out_word_a <= nxt_a;
            out_word_b <= nxt_b;
            out_ovf_a  <= nxt_fa;
            out_ovf_b  <= nxt_fb;
        end
    end

    AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R4
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |->
            ($stable(out_word_a) && $stable(out_word_b)
             && $stable(out_ovf_a) && $stable(out_ovf_b))); // R7
    AST_FLAG_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n))
            |-> ((SWAP_OVF ? out_ovf_b : out_ovf_a) == $past(ovf_even)
              && (SWAP_OVF ? out_ovf_a : out_ovf_b) == $past(ovf_odd))); // R6
endmodule

// File: rtl/ddr_word_rebuild.sv
// Top of the DDR sample rebuilder. One tracker decides the halves; capture
// banks hold the low-half values of both channels and the overflow lane;
// the assembler produces the strobed sample pair.
// Assumes clk runs at twice the output-clock rate with mid-phase edges.
module ddr_word_rebuild #(
    parameter int LANES    = 7,
    parameter bit SWAP_OVF = 1'b0,
    localparam int WORD_W  = 2 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_hi,
    input  logic [LANES-1:0]  lane_a,
    input  logic [LANES-1:0]  lane_b,
    input  logic              ovf_lane,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word_a,
    output logic [WORD_W-1:0] out_word_b,
    output logic              out_ovf_a,
    output logic              out_ovf_b
);
    logic             cap_low;
    logic             fire;
    logic [LANES-1:0] even_a;
    logic [LANES-1:0] even_b;
    logic             ovf_even;

    ddr_phase_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_hi (phase_hi),
        .cap_low  (cap_low),
        .fire     (fire)
    );

    ddr_lane_capture #(.LANES(LANES)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .cap_low(cap_low),
        .lanes_in(lane_a), .even_q(even_a)
    );

    ddr_lane_capture #(.LANES(LANES)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .cap_low(cap_low),
        .lanes_in(lane_b), .even_q(even_b)
    );

    ddr_lane_capture #(.LANES(1)) u_cap_ovf (
        .clk(clk), .rst_n(rst_n), .cap_low(cap_low),
        .lanes_in(ovf_lane), .even_q(ovf_even)
    );

    ddr_word_assembler #(.LANES(LANES), .SWAP_OVF(SWAP_OVF)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .even_a     (even_a),
        .odd_a      (lane_a),
        .even_b     (even_b),
        .odd_b      (lane_b),
        .ovf_even   (ovf_even),
        .ovf_odd    (ovf_lane),
        .out_valid  (out_valid),
        .out_word_a (out_word_a),
        .out_word_b (out_word_b),
        .out_ovf_a  (out_ovf_a),
        .out_ovf_b  (out_ovf_b)
    );

    AST_STROBE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n)) |-> $past(phase_hi)); // R4

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        AST_ODD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(rst_n))
                |-> (out_word_a[2*k+1] == $past(lane_a[k])
                  && out_word_b[2*k+1] == $past(lane_b[k]))); // R3
        AST_EVEN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(rst_n, 2))
                |-> (out_word_a[2*k] == $past(lane_a[k], 2)
                  && out_word_b[2*k] == $past(lane_b[k], 2))); // R2
    end
endmodule

// File: tb/tb_ddr_word_rebuild.sv
module tb_ddr_word_rebuild;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_hi = 1'b0;
    logic [6:0]  lane_a = '0;
    logic [6:0]  lane_b = '0;
    logic        ovf_lane = 1'b0;
    logic        out_valid, out_ovf_a, out_ovf_b;
    logic [13:0] out_word_a, out_word_b;
    logic        sw_valid, sw_ovf_a, sw_ovf_b;
    logic [13:0] sw_word_a, sw_word_b;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ddr_word_rebuild dut (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi),
        .lane_a(lane_a), .lane_b(lane_b), .ovf_lane(ovf_lane),
        .out_valid(out_valid), .out_word_a(out_word_a), .out_word_b(out_word_b),
        .out_ovf_a(out_ovf_a), .out_ovf_b(out_ovf_b)
    );

    ddr_word_rebuild #(.SWAP_OVF(1'b1)) dut_swap (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi),
        .lane_a(lane_a), .lane_b(lane_b), .ovf_lane(ovf_lane),
        .out_valid(sw_valid), .out_word_a(sw_word_a), .out_word_b(sw_word_b),
        .out_ovf_a(sw_ovf_a), .out_ovf_b(sw_ovf_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // DDR serializer model: one half of the output clock, lanes carry bit 2k+hi.
    task automatic drive_half(input bit hi, input logic [13:0] wa, input logic [13:0] wb,
                              input bit ov);
        phase_hi = hi;
        for (int k = 0; k < 7; k++) begin
            lane_a[k] = wa[2*k + int'(hi)];
            lane_b[k] = wb[2*k + int'(hi)];
        end
        ovf_lane = ov;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_word(input logic [13:0] a, input logic [13:0] b,
                             input bit fa, input bit fb);
        drive_half(1'b0, a, b, fa);
        check("R4 no strobe after low half", 32'(out_valid), 32'd0);
        drive_half(1'b1, a, b, fb);
        check("R4 strobe after high half", 32'(out_valid), 32'd1);
        check("R2/R3 word A", 32'(out_word_a), 32'(a));
        check("R8 word B", 32'(out_word_b), 32'(b));
        check("R6 flags straight", {30'd0, out_ovf_a, out_ovf_b}, {30'd0, fa, fb});
        check("R6 flags swapped", {30'd0, sw_ovf_a, sw_ovf_b}, {30'd0, fb, fa});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [13:0] ea, eb;
        // R1: reset with busy lanes.
        lane_a = 7'h55; lane_b = 7'h2A; ovf_lane = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 words in reset", {4'd0, out_word_a, out_word_b}, 32'd0);
        check("R1 flags in reset", {30'd0, out_ovf_a, out_ovf_b}, 32'd0);
        // Reset edge while in a low half: that low half must be forgotten.
        phase_hi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R5: high halves first after reset give no word.
        drive_half(1'b1, 14'h3FFF, 14'h1234, 1'b1);
        check("R5 lone high after reset", 32'(out_valid), 32'd0);
        drive_half(1'b1, 14'h0F0F, 14'h2222, 1'b1);
        check("R5 second high", 32'(out_valid), 32'd0);
        check("R5 words untouched", {4'd0, out_word_a, out_word_b}, 32'd0);

        send_word(14'h1A5C, 14'h2C3D, 1'b1, 1'b0);

        // R9: two lows then a high; last low wins.
        drive_half(1'b0, 14'h3FFF, 14'h3FFF, 1'b1);
        check("R9 no strobe on first low", 32'(out_valid), 32'd0);
        drive_half(1'b0, 14'h0000, 14'h1555, 1'b0);
        check("R9 no strobe on second low", 32'(out_valid), 32'd0);
        drive_half(1'b1, 14'h3FFF, 14'h2AAA, 1'b1);
        ea = 14'h2AAA; eb = 14'h3FFF;
        check("R9 strobe", 32'(out_valid), 32'd1);
        check("R9 word A from last low", 32'(out_word_a), 32'(ea));
        check("R9 word B from last low", 32'(out_word_b), 32'(eb));
        check("R9 flag A from last low", 32'(out_ovf_a), 32'd0);

        // R7: idle in high halves with changing lanes; outputs hold.
        for (int i = 0; i < 8; i++) begin
            drive_half(1'b1, 14'(i * 911), 14'(i * 4099), i[0]);
            check("R7 no strobe when idle", 32'(out_valid), 32'd0);
            check("R7 words held", {4'd0, out_word_a, out_word_b}, {4'd0, ea, eb});
            check("R7 flags held", {30'd0, out_ovf_a, out_ovf_b}, {30'd0, 1'b0, 1'b1});
        end

        // R2/R3/R6/R8: full sweep of channel A, B and flags derived.
        for (int i = 0; i < 16384; i++) begin
            send_word(14'(i), 14'((i * 37 + 5) % 16384), i[0], i[1]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule